// File: doc/BRIEF.md
# Clock-Manager Lock Health Supervisor

This block sits beside an on-chip clock manager and turns its unreliable status into one clean health indication. It watches the manager's raw lock flag, plus two heartbeat toggles. One heartbeat is derived from the reference input clock and the other from the synthesized output clock. All three inputs are first brought into the supervisor's clock domain through two-flop synchronizers.

The raw lock flag cannot be trusted on its own. It may dip and recover after a glitch on the input clock. It may also stay high when the input clock has stopped altogether. The supervisor therefore latches any falling edge of lock as a permanent loss. It also runs a no-activity timeout on each heartbeat, and any timeout that fires is held until reset. Health is good only while lock has been seen, has never been lost, and neither clock has stopped.

A second clock manager fed from the first is held in reset through a release delay line. Its reset is released only after health has stayed good for a fixed number of cycles. It is pulled back into reset in the same cycle that health is lost.

Top module: `clk_health_supervisor`

## Requirements
- R1: A falling edge of the synchronized lock flag sets `lock_lost` to 1 on the third rising clock edge after `lock_raw` falls, and `healthy` is 0 from that same edge.
- R2: Once `lock_lost` is 1, it and a 0 on `healthy` hold until reset, even when `lock_raw` returns high.
- R3: When `ref_beat` shows no change for 64 consecutive clock cycles, `ref_stopped` goes to 1. It stays 1 until reset, even if the heartbeat resumes.
- R4: When `synth_beat` shows no change for 64 consecutive clock cycles, `synth_stopped` goes to 1. It stays 1 until reset, even if the heartbeat resumes.
- R5: `healthy` is 1 exactly when lock has been seen high since reset, `lock_lost` is 0, `ref_stopped` is 0 and `synth_stopped` is 0. Before lock is first seen, `healthy` is 0.
- R6: Heartbeats that change at least once every 40 cycles never raise either stopped flag.
- R7: `down_rst_n` goes to 1 on the 16th rising edge after the edge on which `healthy` became 1.
- R8: `down_rst_n` is 0 in every cycle in which `healthy` is 0, including the very cycle `healthy` falls.
- R9: Synchronous active-low reset clears `lock_lost`, `ref_stopped`, `synth_stopped`, `healthy` and `down_rst_n` to 0.
- R10: With both heartbeats alive, a rise of `lock_raw` makes `healthy` 1 on the third rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_raw | input | 1 | Raw lock flag from the clock manager, asynchronous |
| ref_beat | input | 1 | Toggle derived from the reference input clock, asynchronous |
| synth_beat | input | 1 | Toggle derived from the synthesized clock, asynchronous |
| ref_stopped | output | 1 | Sticky flag: reference heartbeat timed out |
| synth_stopped | output | 1 | Sticky flag: synthesized heartbeat timed out |
| lock_lost | output | 1 | Sticky flag: a falling edge of lock was seen |
| healthy | output | 1 | Overall clock manager health |
| down_rst_n | output | 1 | Active-low reset for the cascaded downstream clock manager |

## Verification
A sticky bit that fails to latch shows up at the ports as `healthy` going high again within three cycles of the raw flag recovering. A heartbeat counter that restarts wrongly, or has the wrong limit, shows as a stopped flag that fires early or never fires. These checks sample the stopped flag well inside the 64-cycle window and well after it. An error in the delay line length shows as `down_rst_n` rising one or more cycles away from the 16th edge after health rises. A missing immediate reassert shows as `down_rst_n` still high in the first cycle with `healthy` low.

// File: rtl/hs_pkg.sv
// Package: shared defaults and the status bundle of the health supervisor.
// Assumes: nothing; pure type and constant definitions.
package hs_pkg;

    // Default count of synchronizer flops in front of every input.
    localparam int unsigned HS_SYNC_STAGES = 2;
    // Default number of quiet cycles that declares a heartbeat dead.
    localparam int unsigned HS_STOP_LIMIT = 64;
    // Default length of the downstream reset release delay line.
    localparam int unsigned HS_DELAY_STAGES = 16;

    // Index of each synchronized input within the synchronizer vector.
    localparam int unsigned HS_IDX_LOCK  = 0;
    localparam int unsigned HS_IDX_REF   = 1;
    localparam int unsigned HS_IDX_SYNTH = 2;
    localparam int unsigned HS_NUM_IN    = 3;

    // Number of heartbeats watched.
    localparam int unsigned HS_NUM_BEATS = 2;

    // Collected status of the supervised clock manager.
    typedef struct packed {
        logic lock_good;
        logic lock_lost;
        logic ref_stop;
        logic synth_stop;
    } hs_status_t;

endpackage

// File: rtl/hs_sync.sv
// Module: hs_sync
// Multi-bit, per-bit synchronizer chain of STAGES flops.
// Assumes: each bit is independent (no bus coherency needed);
// STAGES >= 2. Reset is synchronous and active low.
module hs_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                // Later flops settle any metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/hs_lock_track.sv
// Module: hs_lock_track
// Tracks the synchronized lock flag. It records whether lock has been
// seen high since reset and latches any falling edge as a permanent loss.
// Assumes: lock_s is already synchronized to clk.
module hs_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s,
    output logic lock_good,
    output logic lock_lost
);

    logic prev_q;
    logic seen_q;
    logic lost_q;

    // Edge history, first-lock memory and sticky loss latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            prev_q <= lock_s;
            seen_q <= seen_q | lock_s;
            lost_q <= lost_q | (prev_q & ~lock_s);
        end
    end

    assign lock_good = seen_q & ~lost_q;
    assign lock_lost = lost_q;

    // R1: a falling edge of the synchronized flag is latched on the next edge.
    assert_fall_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_s) |=> lock_lost);

    // R2: loss of lock never clears without reset.
    assert_lost_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |=> lock_lost && !lock_good);

endmodule

// File: rtl/hs_beat_watch.sv
// Module: hs_beat_watch
// Declares a heartbeat dead when it shows no change for LIMIT consecutive
// cycles. The stopped flag is sticky until reset.
// Assumes: beat_s is synchronized to clk; LIMIT >= 2.
module hs_beat_watch #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_s,
    output logic stopped
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic             prev_q;
    logic [CNT_W-1:0] quiet_q;
    logic             stop_q;
    logic             quiet_now;

    assign quiet_now = (beat_s == prev_q);

    // Count consecutive cycles without a heartbeat change; latch timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            quiet_q <= '0;
            stop_q  <= 1'b0;
        end else begin
            prev_q <= beat_s;
            if (!quiet_now)            quiet_q <= '0;
            else if (quiet_q != LAST)  quiet_q <= quiet_q + 1'b1;
            if (quiet_now && quiet_q == LAST) stop_q <= 1'b1;
        end
    end

    assign stopped = stop_q;

    // R3 and R4: a raised stop flag stays raised until reset.
    assert_stop_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);

    // R6: a heartbeat change always restarts the quiet count.
    assert_change_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_s != $past(beat_s)) |=> (quiet_q == '0));

endmodule

// File: rtl/hs_release_delay.sv
// Module: hs_release_delay
// Releases the downstream reset only after health has stayed good for
// STAGES cycles. It asserts that reset again in the same cycle health drops.
// Assumes: STAGES >= 2; health_in is a registered, glitch-free signal.
module hs_release_delay #(
    parameter int unsigned STAGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic health_in,
    output logic release_out
);

    logic [STAGES-1:0] shift_q;

    // Shift in ones while healthy; clear the whole line on any loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !health_in) shift_q <= '0;
        else                      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign release_out = shift_q[STAGES-1] & health_in;

    // R7: release never appears without health in the previous cycle.
    assert_release_after_health_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(release_out) |-> $past(health_in) && health_in);

endmodule

// File: rtl/clk_health_supervisor.sv
// Module: clk_health_supervisor (top)
// Combines lock tracking and two heartbeat watchdogs into one health
// signal, and derives a delayed active-low reset for a cascaded manager.
// Assumes: lock_raw, ref_beat and synth_beat are asynchronous to clk.
// Each heartbeat toggles more than once per STOP_LIMIT cycles when alive.
module clk_health_supervisor #(
    parameter int unsigned SYNC_STAGES  = hs_pkg::HS_SYNC_STAGES,
    parameter int unsigned STOP_LIMIT   = hs_pkg::HS_STOP_LIMIT,
    parameter int unsigned DELAY_STAGES = hs_pkg::HS_DELAY_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_raw,
    input  logic ref_beat,
    input  logic synth_beat,
    output logic ref_stopped,
    output logic synth_stopped,
    output logic lock_lost,
    output logic healthy,
    output logic down_rst_n
);
    import hs_pkg::*;

    logic [HS_NUM_IN-1:0]    raw_vec;
    logic [HS_NUM_IN-1:0]    sync_vec;
    logic [HS_NUM_BEATS-1:0] beat_vec;
    logic [HS_NUM_BEATS-1:0] stop_vec;
    hs_status_t              status;

    assign raw_vec[HS_IDX_LOCK]  = lock_raw;
    assign raw_vec[HS_IDX_REF]   = ref_beat;
    assign raw_vec[HS_IDX_SYNTH] = synth_beat;

    hs_sync #(.WIDTH(HS_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_vec),
        .sync_out (sync_vec)
    );

    hs_lock_track u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_s    (sync_vec[HS_IDX_LOCK]),
        .lock_good (status.lock_good),
        .lock_lost (status.lock_lost)
    );

    assign beat_vec = {sync_vec[HS_IDX_SYNTH], sync_vec[HS_IDX_REF]};

    generate
        for (genvar b = 0; b < HS_NUM_BEATS; b++) begin : g_beat
            hs_beat_watch #(.LIMIT(STOP_LIMIT)) u_watch (
                .clk     (clk),
                .rst_n   (rst_n),
                .beat_s  (beat_vec[b]),
                .stopped (stop_vec[b])
            );
        end
    endgenerate

    assign status.ref_stop   = stop_vec[0];
    assign status.synth_stop = stop_vec[1];

    assign healthy = status.lock_good & ~(status.ref_stop | status.synth_stop);

    hs_release_delay #(.STAGES(DELAY_STAGES)) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .health_in   (healthy),
        .release_out (down_rst_n)
    );

    assign ref_stopped   = status.ref_stop;
    assign synth_stopped = status.synth_stop;
    assign lock_lost     = status.lock_lost;

    // R8: the downstream reset is asserted in the very cycle health falls.
    assert_reassert_at_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(healthy) |-> !down_rst_n);

    // R5: any stop flag raised in the last cycle keeps health low now.
    assert_stop_kills_health_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_stopped) || $past(synth_stopped)) |-> !healthy);

endmodule

// File: tb/tb_clk_health_supervisor.sv
// Scoreboard bench: driver tasks queue expected values keyed by cycle,
// a monitor pops and compares them a quarter period after each edge.
module tb_clk_health_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int SEL_HEALTHY = 0;
    localparam int SEL_LOST    = 1;
    localparam int SEL_REF     = 2;
    localparam int SEL_SYNTH   = 3;
    localparam int SEL_DOWN    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_raw = 1'b0;
    logic ref_beat = 1'b0;
    logic synth_beat = 1'b0;
    logic ref_stopped, synth_stopped, lock_lost, healthy, down_rst_n;

    bit ref_en = 1'b1;
    bit synth_en = 1'b1;
    int ref_per = 4;
    int synth_per = 4;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    cyc;
        int    sel;
        bit    val;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    clk_health_supervisor dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_raw      (lock_raw),
        .ref_beat      (ref_beat),
        .synth_beat    (synth_beat),
        .ref_stopped   (ref_stopped),
        .synth_stopped (synth_stopped),
        .lock_lost     (lock_lost),
        .healthy       (healthy),
        .down_rst_n    (down_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic pick(int sel);
        case (sel)
            SEL_HEALTHY: return healthy;
            SEL_LOST:    return lock_lost;
            SEL_REF:     return ref_stopped;
            SEL_SYNTH:   return synth_stopped;
            default:     return down_rst_n;
        endcase
    endfunction

    function automatic string sname(int sel);
        case (sel)
            SEL_HEALTHY: return "healthy";
            SEL_LOST:    return "lock_lost";
            SEL_REF:     return "ref_stopped";
            SEL_SYNTH:   return "synth_stopped";
            default:     return "down_rst_n";
        endcase
    endfunction

    // Driver side: queue an expectation offset cycles from now.
    task automatic expect_at(int offset, int sel, bit val, string tag);
        exp_t e;
        e.cyc = cyc + offset;
        e.sel = sel;
        e.val = val;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every queued item due in this cycle.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            cyc++;
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].cyc == cyc) begin
                    logic act;
                    act = pick(exp_q[i].sel);
                    checks++;
                    if (act !== exp_q[i].val) begin
                        errors++;
                        $display("FAIL %s cycle %0d %s actual=%b expected=%b",
                                 exp_q[i].tag, cyc, sname(exp_q[i].sel),
                                 act, exp_q[i].val);
                    end
                    exp_q.delete(i);
                end
            end
        end
    end

    // Heartbeat generators, driven on the falling edge.
    initial begin
        int rc = 0;
        int sc = 0;
        forever begin
            @(negedge clk);
            if (ref_en) begin
                rc++;
                if (rc >= ref_per) begin rc = 0; ref_beat = ~ref_beat; end
            end
            if (synth_en) begin
                sc++;
                if (sc >= synth_per) begin sc = 0; synth_beat = ~synth_beat; end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lock_raw = 1'b0;
        ref_en = 1'b1;
        synth_en = 1'b1;
        ref_per = 4;
        synth_per = 4;
        idle(4);
        rst_n = 1'b1;
        // R9: state right after reset release.
        expect_at(1, SEL_HEALTHY, 1'b0, "R9");
        expect_at(1, SEL_LOST,    1'b0, "R9");
        expect_at(1, SEL_REF,     1'b0, "R9");
        expect_at(1, SEL_SYNTH,   1'b0, "R9");
        expect_at(1, SEL_DOWN,    1'b0, "R9");
    endtask

    // Raise lock and check health latency and downstream release timing.
    task automatic raise_lock();
        @(negedge clk);
        lock_raw = 1'b1;
        expect_at(2,  SEL_HEALTHY, 1'b0, "R10");
        expect_at(3,  SEL_HEALTHY, 1'b1, "R10");
        expect_at(18, SEL_DOWN,    1'b0, "R7");
        expect_at(19, SEL_DOWN,    1'b1, "R7");
        idle(30);
    endtask

    // Stimulus.
    initial begin
        do_reset();
        // R5: no lock seen yet, heartbeats alive: not healthy, no stop (R6).
        expect_at(80, SEL_HEALTHY, 1'b0, "R5");
        expect_at(80, SEL_REF,     1'b0, "R6");
        expect_at(80, SEL_SYNTH,   1'b0, "R6");
        expect_at(80, SEL_DOWN,    1'b0, "R8");
        idle(85);

        raise_lock();

        // Two-cycle glitch on the lock flag.
        @(negedge clk);
        lock_raw = 1'b0;
        expect_at(2, SEL_HEALTHY, 1'b1, "R1");
        expect_at(2, SEL_DOWN,    1'b1, "R7");
        expect_at(3, SEL_HEALTHY, 1'b0, "R1");
        expect_at(3, SEL_LOST,    1'b1, "R1");
        expect_at(3, SEL_DOWN,    1'b0, "R8");
        expect_at(40, SEL_LOST,    1'b1, "R2");
        expect_at(40, SEL_HEALTHY, 1'b0, "R2");
        expect_at(40, SEL_DOWN,    1'b0, "R2");
        idle(2);
        lock_raw = 1'b1;
        idle(45);

        // Reference stop scenario.
        do_reset();
        raise_lock();
        @(negedge clk);
        ref_per = 40;
        synth_per = 40;
        expect_at(299, SEL_REF,     1'b0, "R6");
        expect_at(299, SEL_SYNTH,   1'b0, "R6");
        expect_at(299, SEL_HEALTHY, 1'b1, "R6");
        idle(300);
        ref_per = 4;
        synth_per = 4;
        idle(45);
        ref_en = 1'b0;
        expect_at(50,  SEL_REF,     1'b0, "R3");
        expect_at(50,  SEL_HEALTHY, 1'b1, "R3");
        expect_at(100, SEL_REF,     1'b1, "R3");
        expect_at(100, SEL_HEALTHY, 1'b0, "R5");
        expect_at(100, SEL_DOWN,    1'b0, "R8");
        expect_at(100, SEL_SYNTH,   1'b0, "R4");
        expect_at(100, SEL_LOST,    1'b0, "R5");
        idle(100);
        ref_en = 1'b1;
        expect_at(60, SEL_REF,     1'b1, "R3");
        expect_at(60, SEL_HEALTHY, 1'b0, "R3");
        idle(65);

        // Synthesized clock stop scenario.
        do_reset();
        raise_lock();
        @(negedge clk);
        synth_en = 1'b0;
        expect_at(50,  SEL_SYNTH,   1'b0, "R4");
        expect_at(100, SEL_SYNTH,   1'b1, "R4");
        expect_at(100, SEL_REF,     1'b0, "R3");
        expect_at(100, SEL_HEALTHY, 1'b0, "R5");
        expect_at(100, SEL_DOWN,    1'b0, "R8");
        idle(100);
        synth_en = 1'b1;
        expect_at(60, SEL_SYNTH, 1'b1, "R4");
        idle(65);

        while (exp_q.size() != 0) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule